// File: doc/BRIEF.md
# Serially Loaded Bank-Control Register File

This block holds the four 5-bit control registers of a bank-switching controller and lets a CPU load them through a one-bit-wide path. The CPU writes a byte into the upper half of its address space. Each such write contributes one data bit to a hidden shift register. The fifth write hands the collected 5-bit word to one of the four registers, and the address of that fifth write picks which one. The addresses of the four earlier writes play no part in the choice.

A second bit in the written byte acts as an abort flag. It throws away any partly collected word and restarts the count. It also forces two mode bits in the control register to one and leaves every other stored bit as it was. The four register values come out as one flat registered vector. Bank address translation uses this vector and is built elsewhere.

Top module: `serial_bank_regfile`

## Requirements
- R1: A write with `wr_en` low, or with `addr[15]` equal to 0 (addresses below 0x8000), leaves the shift state and all four registers unchanged.
- R2: A register load takes exactly five accepted writes. The first accepted write supplies bit 0 of the loaded value and the fifth supplies bit 4.
- R3: Only `wdata[0]` (data bit) and `wdata[7]` (abort flag) have any effect. The values of `wdata[6:1]` never change the outcome.
- R4: The fifth write's `addr[14:13]` chooses the destination: 00 is the control register (slice 0), 01 is slice 1, 10 is slice 2 and 11 is slice 3. Slice k occupies `regs_o[5k+4:5k]`. The addresses of writes one to four have no effect.
- R5: The loaded value appears on `regs_o` on the clock edge after the fifth write. The shift state then restarts, so the next accepted write counts as bit 0 of a new word.
- R6: Writes one to four of a sequence change no register, even when they target the address of a register.
- R7: An accepted write with `wdata[7]` = 1 ignores `wdata[0]`, discards the partial word and restarts the count. It sets bits 3:2 of the control register and leaves all other bits of all four registers unchanged.
- R8: After synchronous reset, slices 1 to 3 read 0 and the control register reads 0b01100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, sampled on each rising edge |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write byte; bit 7 is the abort flag, bit 0 is the data bit |
| regs_o | output | 20 | Four 5-bit registers; slice 0 (bits 4:0) is the control register |

## Verification
The bench goes after a fifth write whose address differs from that of the first four. A design that latched the destination early would fill the wrong slice. It aborts sequences part-way and then runs a full load: a counter that was not cleared would commit after too few writes, and an abort that touched more than bits 3:2 would corrupt the control register. It also mixes low-address writes and strobe-less cycles into running sequences, so that a design counting those would shift in a stray bit. Random noise on `wdata[6:1]` exposes any decode of the unused bits.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  // Byte-lane positions that the controller decodes from the CPU write data.
  localparam int unsigned ABORT_BIT = 7;
  localparam int unsigned DBIT      = 0;
  // Control register index and the mode bits forced by an abort.
  localparam int unsigned CTRL_IDX  = 0;
  localparam int unsigned MODE_LO   = 2;
  localparam int unsigned MODE_HI   = 3;

  function automatic logic [31:0] mode_mask();
    logic [31:0] m;
    m = '0;
    for (int i = MODE_LO; i <= MODE_HI; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sbr_collector.sv
module sbr_collector #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned CNT_W  = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             abort_i,
  input  logic             dbit_i,
  output logic             commit_o,
  output logic             preset_o,
  output logic [REG_W-1:0] value_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [REG_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;

  // Incoming bit enters at the top; after REG_W shifts the first bit sits at bit 0.
  assign value_o  = {dbit_i, sr_q[REG_W-1:1]};
  assign commit_o = hit_i && !abort_i && (cnt_q == LAST);
  assign preset_o = hit_i && abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (hit_i) begin
      if (abort_i || cnt_q == LAST) begin
        sr_q  <= '0;
        cnt_q <= '0;
      end else begin
        sr_q  <= value_o;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the bit counter never runs past the word length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R7: an abort restarts the count
  a_r7_abort_restart: assert property (@(posedge clk) disable iff (rst)
    preset_o |=> (cnt_q == '0));
  // R5: a commit restarts the count
  a_r5_commit_restart: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> (cnt_q == '0));
  // R1: no accepted write, no shift
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> ($stable(cnt_q) && $stable(sr_q)));
endmodule

// File: rtl/sbr_bank.sv
module sbr_bank
  import sbr_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      commit_i,
  input  logic                      preset_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [REG_W-1:0]          value_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam logic [REG_W-1:0] MODE_SET = REG_W'(mode_mask());

  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == CTRL_IDX) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst)                            regs_q[g] <= MODE_SET;
        else if (preset_i)                  regs_q[g] <= regs_q[g] | MODE_SET;
        else if (commit_i && sel_i == SEL_W'(g)) regs_q[g] <= value_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                            regs_q[g] <= '0;
        else if (commit_i && sel_i == SEL_W'(g)) regs_q[g] <= value_i;
      end
    end
  end

  assign regs_o = regs_q;

  // R6: without a commit or abort nothing stored moves
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!commit_i && !preset_i) |=> $stable(regs_q));
  // R4: a commit lands in the selected slice
  a_r4_commit_dest: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (regs_q[$past(sel_i)] == $past(value_i)));
  // R7: abort forces the mode bits
  a_r7_mode_bits: assert property (@(posedge clk) disable iff (rst)
    preset_i |=> (regs_q[CTRL_IDX][MODE_HI:MODE_LO] == 2'b11));
  // R7: commit and abort never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(commit_i && preset_i));
endmodule

// File: rtl/serial_bank_regfile.sv
module serial_bank_regfile
  import sbr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam int unsigned SEL_W   = $clog2(NUM_REGS);
  localparam int unsigned SEL_LSB = ADDR_W - 1 - SEL_W;

  logic             hit, commit, preset;
  logic [SEL_W-1:0] sel;
  logic [REG_W-1:0] value;
  logic             unused_bits;

  assign hit = wr_en && addr[ADDR_W-1];
  assign sel = addr[ADDR_W-2 -: SEL_W];
  assign unused_bits = ^{addr[SEL_LSB-1:0], wdata[ABORT_BIT-1:DBIT+1]};

  sbr_collector #(.REG_W(REG_W)) u_coll (
    .clk     (clk),
    .rst     (rst),
    .hit_i   (hit),
    .abort_i (wdata[ABORT_BIT]),
    .dbit_i  (wdata[DBIT]),
    .commit_o(commit),
    .preset_o(preset),
    .value_o (value)
  );

  sbr_bank #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .commit_i(commit),
    .preset_i(preset),
    .sel_i   (sel),
    .value_i (value),
    .regs_o  (regs_o)
  );

  // R1: writes outside the window never commit or abort
  a_r1_window: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (!commit && !preset));
endmodule

// File: tb/serial_bank_regfile_tb.sv
`timescale 1ns/1ps
module serial_bank_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [19:0] regs_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [4:0] m_reg [4];
  logic [4:0] m_sr;
  int         m_cnt;

  always #10 clk = ~clk;

  serial_bank_regfile dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .regs_o(regs_o)
  );

  task automatic check_all(input string tag);
    for (int k = 0; k < 4; k++) begin
      n_chk++;
      if (regs_o[5*k +: 5] !== m_reg[k]) begin
        n_fail++;
        $display("FAIL %s slice %0d: actual %b expected %b", tag, k, regs_o[5*k +: 5], m_reg[k]);
      end
    end
  endtask

  function automatic string model_write(input logic en, input logic [15:0] a, input logic [7:0] d);
    if (!en || !a[15]) return "R1";
    if (d[7]) begin
      m_sr = '0; m_cnt = 0;
      m_reg[0] = m_reg[0] | 5'b01100;
      return "R7";
    end
    m_sr = {d[0], m_sr[4:1]};
    if (m_cnt == 4) begin
      m_reg[a[14:13]] = m_sr;
      m_sr = '0; m_cnt = 0;
      return "R4";
    end
    m_cnt++;
    return "R6";
  endfunction

  task automatic cpu_wr(input logic en, input logic [15:0] a, input logic [7:0] d,
                        input string tag_over = "");
    string tag;
    @(negedge clk);
    wr_en = en; addr = a; wdata = d;
    @(posedge clk);
    tag = model_write(en, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag_over != "" ? tag_over : tag);
  endtask

  task automatic load(input logic [4:0] v, input logic [15:0] first_a,
                      input logic [15:0] last_a, input string tag);
    for (int i = 0; i < 5; i++)
      cpu_wr(1'b1, (i == 4) ? last_a : first_a, {1'b0, 6'($urandom), v[i]}, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240517));
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    m_reg[0] = 5'b01100; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
    m_sr = '0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_all("R8");

    // R2/R4: one load into each slice, LSB first
    load(5'b00001, 16'h8000, 16'h9FFF, "R2");
    load(5'b10110, 16'hA000, 16'hA123, "R4");
    load(5'b01011, 16'hC000, 16'hDFFF, "R4");
    load(5'b11101, 16'hE000, 16'hE000, "R4");
    // R4/R6: first four addresses point at slice 0, fifth at slice 3
    load(5'b00000, 16'h8000, 16'hE000, "R6");
    load(5'b10011, 16'hE000, 16'hA000, "R4");
    // R3: noise on bits 6..1 must not matter
    for (int i = 0; i < 5; i++) cpu_wr(1'b1, 16'hC400, 8'b0111_1110 | 8'(i[0]), "R3");
    // R7: abort two bits into a sequence, data bit set, then a fresh load
    load(5'b00000, 16'h8000, 16'h8000, "R7");
    cpu_wr(1'b1, 16'hA000, 8'h01, "R2");
    cpu_wr(1'b1, 16'hA000, 8'h01, "R2");
    cpu_wr(1'b1, 16'hF000, 8'h81, "R7");
    load(5'b01010, 16'hC000, 16'hA000, "R5");
    // R1: low addresses and idle strobes inside a sequence
    cpu_wr(1'b1, 16'hC000, 8'h01);
    cpu_wr(1'b1, 16'h7FFF, 8'h81);
    cpu_wr(1'b0, 16'h8000, 8'h81);
    cpu_wr(1'b1, 16'hC000, 8'h00);
    cpu_wr(1'b1, 16'h0000, 8'h01);
    cpu_wr(1'b1, 16'hC000, 8'h01);
    cpu_wr(1'b1, 16'hC000, 8'h00);
    cpu_wr(1'b1, 16'hC000, 8'h01, "R5");

    // Random mix
    for (int i = 0; i < 800; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int          r;
      r = int'($urandom_range(0, 31));
      a = 16'($urandom);
      d = 8'($urandom);
      d[7] = (r == 0);
      if (r > 3) a[15] = 1'b1;
      cpu_wr(r != 1, a, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule